// File: doc/BRIEF.md
# DRAM Refresh Row Counter with Selectable Terminal Count

This block supplies the row address for DRAM refresh and keeps track of how far a refresh sweep has progressed. A 9-bit row counter steps once each time the access sequencer finishes a refresh cycle. The counter starts again from zero once it passes a terminal count that software selects: 127, 255 or 511. One shared open-drain style refresh pin carries the block's status. The pin is driven low when the counter sits on its terminal count, or when a forced refresh is pending. When the block is not driving the pin, an external low on it clears the counter.

A 3-bit mode input selects the behaviour. Mode 7 is the set-up mode that loads the terminal-count select. Mode 2 is a burst refresh: the block asks the sequencer for back-to-back refresh cycles until the row at the terminal count has been refreshed. Mode 5 is automatic access with hidden refresh: an interval timer watches for completed refreshes, and if none arrives in time the block raises a forced-refresh request on the pin. The system then performs the forced refresh in mode 1, and the request drops when that refresh completes. The sequencer reports each refresh cycle on a strobe that is high for the length of the cycle. The block treats the falling edge of that strobe as the completion of the refresh.

Top module: `rfsh_ctr_top`

## Requirements
- R1: After synchronous reset the row address is 0, the terminal-count select is 127, the pin is not driven, no request is pending and the burst output is low.
- R2: A clock edge in mode 7 loads the select from `lim_sel_i`. 2'b00 selects 127, 2'b01 selects 255, and 2'b1x selects 511. In every other mode the select holds its value.
- R3: The row address increases by one at the first clock edge at which `rstrb_i` is sampled low after it was sampled high. At all other edges the row address holds, unless R6 applies.
- R4: A completion edge while the row address equals the selected terminal count sets the row address to 0.
- R5: In every mode except 1 and 5, `rio_oe_o` is high exactly while the row address equals the selected terminal count.
- R6: While `rio_oe_o` is low, sampling `rio_i` low at a clock edge clears the row address to 0 and takes priority over R3. While `rio_oe_o` is high, `rio_i` is ignored.
- R7: In mode 2, `burst_run_o` is high until a refresh completes with the row address at the terminal count. It then stays low until the mode leaves 2. Re-entering mode 2 raises it again.
- R8: In mode 5, INTERVAL consecutive clock edges with no refresh completion (counted from the last completion) raise the forced-refresh request. In modes 1 and 5, `rio_oe_o` shows that request instead of the terminal-count flag.
- R9: The request stays set until a refresh completes in mode 1, and is clear from the next edge. A completion in mode 5 does not clear it. Any completion restarts the interval count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Operating mode |
| lim_sel_i | input | 2 | Terminal-count select, loaded in mode 7 |
| rstrb_i | input | 1 | Refresh strobe from the access sequencer; its falling edge marks completion |
| rio_i | input | 1 | Sampled level of the shared refresh pin |
| rio_oe_o | output | 1 | Drives the shared refresh pin low when high |
| row_addr_o | output | 9 | Refresh row address |
| burst_run_o | output | 1 | Burst refresh wanted from the sequencer |

## Verification
The row address, the loaded select, the burst-done state and the request are all registered. Each of them reflects a stimulus at the first rising edge that samples it. A falling strobe driven at a negative edge therefore shows up at the next negative edge, and a strobe pulse takes two edges from rise to updated count. `rio_oe_o` and `burst_run_o` also follow `mode_i` combinationally within the same cycle. The bench drives all inputs at negative edges and compares every output just before it changes the inputs. A bench reference model steps at each rising edge, so every comparison is made against the state that the last edge produced.

// File: rtl/rfsh_pkg.sv
// Package: shared mode encoding for the refresh row counter.
// Assumes a 3-bit mode bus; only modes 1, 2, 5 and 7 change this block's behaviour.
package rfsh_pkg;

    typedef enum logic [2:0] {
        MODE_EXT_ACCESS  = 3'd0,
        MODE_FORCED      = 3'd1,
        MODE_BURST       = 3'd2,
        MODE_ALL_ROW     = 3'd3,
        MODE_EXT_REFRESH = 3'd4,
        MODE_AUTO_HIDDEN = 3'd5,
        MODE_AUTO_FAST   = 3'd6,
        MODE_SETUP       = 3'd7
    } rfsh_mode_e;

    typedef logic [1:0] lim_sel_t;

endpackage

// File: rtl/rfsh_limit_reg.sv
// Module: terminal-count select register.
// Holds the 2-bit select that is loaded in set-up mode and turns it into a count value.
// Assumes CW >= 3. The select resets to the smallest limit, 2^(CW-2)-1.
module rfsh_limit_reg
    import rfsh_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  lim_sel_t      sel_i,
    output logic [CW-1:0] limit_o
);

    localparam logic [CW-1:0] LIM_SMALL = {2'b00, {(CW-2){1'b1}}};
    localparam logic [CW-1:0] LIM_MID   = {1'b0,  {(CW-1){1'b1}}};
    localparam logic [CW-1:0] LIM_FULL  = {CW{1'b1}};

    lim_sel_t sel_q;

    // Purpose: capture the select while in set-up mode, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 2'b00;
        end else if (load_i) begin
            sel_q <= sel_i;
        end
    end

    // Purpose: decode the held select into the terminal count value.
    always_comb begin
        if (sel_q[1]) begin
            limit_o = LIM_FULL;
        end else if (sel_q[0]) begin
            limit_o = LIM_MID;
        end else begin
            limit_o = LIM_SMALL;
        end
    end

    // R2: select only moves in set-up mode
    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sel_q));
    // R2: set-up mode loads the presented select
    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sel_q == $past(sel_i)));

endmodule

// File: rtl/rfsh_row_ctr.sv
// Module: refresh row counter.
// Detects the falling edge of the refresh strobe and steps the row address on it.
// Wraps to zero after the terminal count and clears on request.
// Assumes the strobe is synchronous to clk. Clear has priority over a step.
module rfsh_row_ctr #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic          clr_i,
    input  logic [CW-1:0] limit_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o,
    output logic          at_limit_o
);

    logic          strb_q;
    logic [CW-1:0] cnt_q;

    // Purpose: remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
        end else begin
            strb_q <= strobe_i;
        end
    end

    assign done_o     = strb_q & ~strobe_i;
    assign at_limit_o = (cnt_q == limit_i);
    assign cnt_o      = cnt_q;

    // Purpose: clear, wrap or step the row address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (done_o) begin
            if (at_limit_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R6: an accepted clear empties the counter
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
    // R4: completion at the terminal count wraps to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && at_limit_o && !clr_i) |=> (cnt_q == '0));
    // R3: completion below the terminal count steps by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !at_limit_o && !clr_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
    // R3: no completion and no clear means no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rfsh_burst_ctl.sv
// Module: burst refresh control.
// While burst mode is selected it asks for refresh cycles until the row at
// the terminal count has been refreshed. It then stays quiet until burst mode is left.
// Assumes the sequencer issues strobes only while burst_run_o is high.
module rfsh_burst_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode_i,
    input  logic done_i,
    input  logic at_limit_i,
    input  logic clr_i,
    output logic burst_run_o
);

    logic fin_q;

    // Purpose: latch the end of the sweep; forget it on leaving burst mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
        end else if (!burst_mode_i) begin
            fin_q <= 1'b0;
        end else if (done_i && at_limit_i && !clr_i) begin
            fin_q <= 1'b1;
        end
    end

    assign burst_run_o = burst_mode_i & ~fin_q;

    // R7: the sweep ends when the terminal row has been refreshed
    a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode_i && done_i && at_limit_i && !clr_i) |=> fin_q);
    // R7: a finished sweep stays finished while in burst mode
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode_i && fin_q) |=> fin_q);
    // R7: leaving burst mode re-arms the sweep
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_mode_i |=> !fin_q);

endmodule

// File: rtl/rfsh_force_req.sv
// Module: forced-refresh request timer.
// In automatic access mode it counts cycles since the last refresh completion.
// It raises a request after INTERVAL of them. A completion in forced mode drops the request.
// Assumes INTERVAL >= 2. The timer holds in modes other than automatic access.
module rfsh_force_req #(
    parameter int INTERVAL = 16,
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_mode_i,
    input  logic forced_mode_i,
    input  logic done_i,
    output logic req_o
);

    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] tmr_q;
    logic          req_q;
    logic          expire;

    assign expire = auto_mode_i && !req_q && !done_i && (tmr_q == LAST);

    // Purpose: restart the timer on completion, advance it while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (done_i) begin
            tmr_q <= '0;
        end else if (auto_mode_i && !req_q) begin
            if (tmr_q == LAST) begin
                tmr_q <= '0;
            end else begin
                tmr_q <= tmr_q + TW'(1);
            end
        end
    end

    // Purpose: set the request on expiry, drop it when the forced refresh completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (expire) begin
            req_q <= 1'b1;
        end else if (forced_mode_i && done_i) begin
            req_q <= 1'b0;
        end
    end

    assign req_o = req_q;

    // R9: a completion in forced mode clears the request
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && forced_mode_i && done_i) |=> !req_q);
    // R9: otherwise a pending request persists
    a_r9_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !(forced_mode_i && done_i)) |=> req_q);
    // R8: a request only appears out of automatic access mode
    a_r8_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_q && !auto_mode_i) |=> !req_q);

endmodule

// File: rtl/rfsh_ctr_top.sv
// Module: refresh row counter top.
// Decodes the mode and drives the shared refresh pin. It connects the
// limit register, the row counter, the burst control and the forced-refresh timer.
// Assumes all inputs, including the sampled pin level, are synchronous to clk.
module rfsh_ctr_top
    import rfsh_pkg::*;
#(
    parameter int CW       = 9,
    parameter int INTERVAL = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_i,
    input  logic [1:0]    lim_sel_i,
    input  logic          rstrb_i,
    input  logic          rio_i,
    output logic          rio_oe_o,
    output logic [CW-1:0] row_addr_o,
    output logic          burst_run_o
);

    rfsh_mode_e    mode;
    logic [CW-1:0] limit;
    logic          done;
    logic          at_limit;
    logic          clr;
    logic          req;
    logic          req_view;

    assign mode     = rfsh_mode_e'(mode_i);
    assign req_view = (mode == MODE_FORCED) || (mode == MODE_AUTO_HIDDEN);

    // Purpose: pick what the shared pin reports, and accept an external clear only while not driving.
    always_comb begin
        rio_oe_o = req_view ? req : at_limit;
        clr      = !rio_oe_o && !rio_i;
    end

    rfsh_limit_reg #(.CW(CW)) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (mode == MODE_SETUP),
        .sel_i   (lim_sel_i),
        .limit_o (limit)
    );

    rfsh_row_ctr #(.CW(CW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (rstrb_i),
        .clr_i      (clr),
        .limit_i    (limit),
        .cnt_o      (row_addr_o),
        .done_o     (done),
        .at_limit_o (at_limit)
    );

    rfsh_burst_ctl u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode_i (mode == MODE_BURST),
        .done_i       (done),
        .at_limit_i   (at_limit),
        .clr_i        (clr),
        .burst_run_o  (burst_run_o)
    );

    rfsh_force_req #(.INTERVAL(INTERVAL)) u_force (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_mode_i   (mode == MODE_AUTO_HIDDEN),
        .forced_mode_i (mode == MODE_FORCED),
        .done_i        (done),
        .req_o         (req)
    );

    // R6: the pin is never sampled while the block drives it
    a_r6_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rio_oe_o |=> ($past(row_addr_o) == '0) || (row_addr_o != '0) || $past(done));

endmodule

// File: tb/tb_rfsh_ctr_top.sv
`timescale 1ns/1ps
module tb_rfsh_ctr_top;

    localparam int CW  = 9;
    localparam int IVL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic [1:0]    bsel = 2'b00;
    logic          rstrb = 1'b0;
    logic          rio = 1'b1;
    logic          oe;
    logic [CW-1:0] row;
    logic          brun;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    bit cmp_on = 0;

    // reference model state
    logic [CW-1:0] m_cnt;
    logic [1:0]    m_sel;
    logic          m_fin, m_req, m_sq;
    int            m_tmr;

    always #5 clk = ~clk;

    rfsh_ctr_top #(.CW(CW), .INTERVAL(IVL)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .lim_sel_i(bsel),
        .rstrb_i(rstrb), .rio_i(rio), .rio_oe_o(oe),
        .row_addr_o(row), .burst_run_o(brun)
    );

    function automatic logic [CW-1:0] lim_of(input logic [1:0] s);
        if (s[1]) return 9'd511;
        if (s[0]) return 9'd255;
        return 9'd127;
    endfunction

    function automatic logic exp_oe();
        if (mode == 3'd1 || mode == 3'd5) return m_req;
        return (m_cnt == lim_of(m_sel));
    endfunction

    function automatic logic exp_brun();
        return (mode == 3'd2) && !m_fin;
    endfunction

    // model advances on each rising edge from the requirement rules
    always @(posedge clk) begin
        logic tr, cl, atl;
        if (!rst_n) begin
            m_cnt <= '0; m_sel <= 2'b00; m_fin <= 1'b0;
            m_req <= 1'b0; m_sq <= 1'b0; m_tmr <= 0;
        end else begin
            tr  = m_sq && !rstrb;
            cl  = !exp_oe() && !rio;
            atl = (m_cnt == lim_of(m_sel));
            m_sq <= rstrb;
            if (cl) m_cnt <= '0;
            else if (tr) m_cnt <= atl ? '0 : m_cnt + 9'd1;
            if (mode == 3'd7) m_sel <= bsel;
            if (mode != 3'd2) m_fin <= 1'b0;
            else if (tr && atl && !cl) m_fin <= 1'b1;
            if (tr) m_tmr <= 0;
            else if (mode == 3'd5 && !m_req) m_tmr <= (m_tmr == IVL-1) ? 0 : m_tmr + 1;
            if (mode == 3'd5 && !m_req && !tr && m_tmr == IVL-1) m_req <= 1'b1;
            else if (mode == 3'd1 && tr) m_req <= 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse();
        rstrb = 1'b1;
        @(negedge clk);
        rstrb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_limit(input logic [1:0] s);
        mode = 3'd7; bsel = s;
        @(negedge clk);
        mode = 3'd0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'h1d5e_ed01));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 row", row, 0);
        chk("R1 oe", oe, 0);
        chk("R1 burst", brun, 0);

        // R3: one completion steps by one
        pulse();
        chk("R3 step", row, 1);
        rstrb = 1'b1; idle(3);
        chk("R3 hold while high", row, 1);
        rstrb = 1'b0; @(negedge clk);
        chk("R3 step on fall", row, 2);

        // R2/R5: default limit 127
        pulses(125);
        chk("R2 default row", row, 127);
        chk("R5 eoc at 127", oe, 1);
        // R4: wrap
        pulse();
        chk("R4 wrap", row, 0);
        chk("R5 eoc off", oe, 0);

        // R2: select 255
        set_limit(2'b01);
        pulses(127);
        chk("R5 no eoc at 127 with 255", oe, 0);
        pulses(128);
        chk("R2 row 255", row, 255);
        chk("R5 eoc at 255", oe, 1);
        // R6: ignored while driving
        rio = 1'b0; @(negedge clk); rio = 1'b1;
        chk("R6 ignored while driving", row, 255);
        pulse();
        chk("R4 wrap 255", row, 0);
        // R6: external clear
        pulses(5);
        rio = 1'b0; @(negedge clk); rio = 1'b1;
        chk("R6 clear", row, 0);
        // R2: set-up mode with another mode present leaves select alone
        mode = 3'd2; bsel = 2'b00; @(negedge clk); mode = 3'd0;
        pulses(127);
        chk("R2 hold outside setup", oe, 0);
        rio = 1'b0; @(negedge clk); rio = 1'b1;

        // R7: burst sweep with 511 limit (1x code)
        set_limit(2'b11);
        mode = 3'd2;
        #1;
        chk("R7 burst start", brun, 1);
        n = 0;
        while (brun && n < 600) begin pulse(); n++; end
        chk("R7 burst length", n, 512);
        chk("R7 burst end row", row, 0);
        idle(3);
        chk("R7 stays stopped", brun, 0);
        mode = 3'd0; @(negedge clk);
        mode = 3'd2; #1;
        chk("R7 rearm", brun, 1);
        mode = 3'd0; @(negedge clk);

        // R8: forced request after IVL quiet edges in mode 5
        pulse();
        mode = 3'd5;
        idle(IVL - 1);
        chk("R8 not yet", oe, 0);
        idle(1);
        chk("R8 request", oe, 1);
        pulse();
        chk("R9 hidden keeps request", oe, 1);
        mode = 3'd1; pulse();
        chk("R9 forced clears", oe, 0);
        // R9: a completion restarts the interval
        mode = 3'd5;
        idle(IVL - 3);
        pulse();
        idle(IVL - 1);
        chk("R9 restart", oe, 0);
        idle(1);
        chk("R8 request again", oe, 1);
        mode = 3'd1; pulse();
        mode = 3'd0; @(negedge clk);

        // random phase against the model
        cmp_on = 1;
        for (int c = 0; c < 6000; c++) begin
            chk("R3 row model", row, m_cnt);
            chk("R5 pin model", oe, exp_oe());
            chk("R7 burst model", brun, exp_brun());
            if (c % 64 == 0) begin
                case ($urandom % 6)
                    0: mode = 3'd0;
                    1: mode = 3'd1;
                    2: mode = 3'd2;
                    3: mode = 3'd5;
                    4: mode = 3'd7;
                    default: mode = 3'($urandom % 8);
                endcase
            end
            bsel  = 2'($urandom % 4);
            rstrb = ($urandom % 3) == 0;
            rio   = ($urandom % 50) != 0;
            @(negedge clk);
        end
        finish_run();
    end

endmodule